// File: doc/BRIEF.md
# Display Link Lane and Rate Selector

This block picks the number of lanes and the per-lane link rate that a display link needs in order to carry a video mode of a given pixel clock. A request carries the pixel clock in kHz, the monitor's bits per colour component, the sink's largest lane count, the sink's largest link rate, a flag saying that the sink supports the 540000 kHz rate, and a flag that pins the rate to 270000 kHz for an external bridge. The block answers with a lane count, a link rate and a flag saying whether the mode can be driven.

The search is done in two passes. The first pass fixes the lane count. It uses the sink's top rate and starts at one lane, doubling the count until the capacity is enough or the sink's lane limit is reached. The second pass holds that lane count and tries the standard rates from the slowest up. Each candidate costs one clock. A pulse on `start` launches a request while the block is idle. `done` pulses once when the answer is ready, and the answer then holds until the next request completes.

Top module: `link_cfg_sel`

## Requirements
- R1: Bits per pixel is 24 when `bpc` is 0, and 3 × `bpc` for any other value. A `bpc` of 0 therefore selects the same configuration as a `bpc` of 8.
- R2: A candidate of rate r (kHz) and n lanes fits a pixel clock p when p ≤ floor(r × n × 8 / bpp). A pixel clock exactly at that bound fits. One more kHz does not fit.
- R3: The lane count starts at 1 and doubles as long as it is below `sink_lanes`. The search stops at the first count that fits at `sink_rate`. If no count fits, it stops where the doubling ends. `lanes` is always one-hot.
- R4: With the lane count fixed, the rates 162000 and then 270000 are tried in that order. The first one that fits becomes `rate`.
- R5: The rate 540000 is tried third, and only when `fast_cap` is 1. When no tried rate fits, `rate` equals `sink_rate`.
- R6: When `bridge_fix` is 1, `rate` is 270000 regardless of fit. The lane count is still chosen as in R3.
- R7: `mode_ok` is 0 exactly when the chosen rate is 540000 and `fast_cap` is 0.
- R8: `start` is taken only while `busy` is 0. A `start` during a search is ignored. `done` is high for exactly one cycle, and at that point `busy` is already low. `lanes`, `rate` and `mode_ok` change only at `done` and otherwise hold.
- R9: After reset, `busy` and `done` are 0, and `lanes`, `rate` and `mode_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a request while idle |
| pix_khz | input | PIX_W | Pixel clock in kHz |
| bpc | input | BPC_W | Monitor bits per colour, 0 means unknown |
| sink_lanes | input | LANE_W | Largest lane count the sink accepts |
| sink_rate | input | RATE_W | Largest link rate of the sink in kHz |
| fast_cap | input | 1 | Sink accepts the 540000 kHz rate |
| bridge_fix | input | 1 | Forces the rate to 270000 kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the answer is ready |
| lanes | output | LANE_W+1 | Chosen lane count |
| rate | output | RATE_W | Chosen link rate in kHz |
| mode_ok | output | 1 | Mode can be driven |

## Verification
The main sweep crosses several colour depths (including 0 against 8, which must agree) with sink lane limits of 1, 2 and 4, sink top rates of 162000, 270000 and 540000, both states of the fast-rate and bridge flags, and pixel clocks placed on either side of the capacity bounds. This separates an early lane stop from a stop at the lane limit, and a fit at each standard rate from the fallback to the sink's rate. It also catches a 540000 pick that must be flagged invalid. Directed cases hit the exact integer-division bound and the one-kHz-over point. A further case sends a second `start` mid-search with different inputs and confirms that the answer still belongs to the first request and that no extra `done` appears.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LANE = 2'd1,
      ST_RATE = 2'd2
   } lcs_state_t;
endpackage

// File: rtl/lcs_bpp.sv
module lcs_bpp #(
   parameter int BPC_W = 4,
   parameter int BPP_W = BPC_W + 2
) (
   input  logic [BPC_W-1:0] bpc,
   output logic [BPP_W-1:0] bpp
);
   // unknown depth defaults to 8 bits per colour
   always_comb begin
      if (bpc == '0) bpp = BPP_W'(24);
      else           bpp = BPP_W'(bpc) * BPP_W'(3);
   end
endmodule

// File: rtl/lcs_fit.sv
module lcs_fit #(
   parameter int PIX_W  = 20,
   parameter int BPP_W  = 6,
   parameter int RATE_W = 20,
   parameter int CNT_W  = 4,
   parameter int PROD_W = RATE_W + CNT_W + 3
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic [BPP_W-1:0]  bpp,
   input  logic [RATE_W-1:0] rate,
   input  logic [CNT_W-1:0]  lanes,
   output logic              fits
);
   // p <= floor(X / bpp)  <=>  p * bpp <= X  for integer p
   logic [PROD_W-1:0] need, have;
   always_comb begin
      need = PROD_W'(pix) * PROD_W'(bpp);
      have = (PROD_W'(rate) * PROD_W'(lanes)) << 3;
      fits = (need <= have);
   end
endmodule

// File: rtl/link_cfg_sel.sv
module link_cfg_sel
   import lcs_pkg::*;
#(
   parameter int PIX_W   = 20,
   parameter int BPC_W   = 4,
   parameter int LANE_W  = 3,
   parameter int RATE_W  = 20,
   parameter int RATE_LO  = 162000,
   parameter int RATE_MID = 270000,
   parameter int RATE_HI  = 540000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PIX_W-1:0]  pix_khz,
   input  logic [BPC_W-1:0]  bpc,
   input  logic [LANE_W-1:0] sink_lanes,
   input  logic [RATE_W-1:0] sink_rate,
   input  logic              fast_cap,
   input  logic              bridge_fix,
   output logic              busy,
   output logic              done,
   output logic [LANE_W:0]   lanes,
   output logic [RATE_W-1:0] rate,
   output logic              mode_ok
);
   localparam int BPP_W  = BPC_W + 2;
   localparam int CNT_W  = LANE_W + 1;
   localparam int PROD_W = RATE_W + CNT_W + 3;
   localparam logic [RATE_W-1:0] R_LO  = RATE_W'(RATE_LO);
   localparam logic [RATE_W-1:0] R_MID = RATE_W'(RATE_MID);
   localparam logic [RATE_W-1:0] R_HI  = RATE_W'(RATE_HI);

   if (BPC_W < 3) begin : g_bad_bpc
      $error("BPC_W must hold at least 3 bits so that 24 bpp fits");
   end
   if (RATE_HI >= (1 << RATE_W)) begin : g_bad_rate
      $error("RATE_W too narrow for the top standard rate");
   end
   if (!(RATE_LO < RATE_MID && RATE_MID < RATE_HI)) begin : g_bad_order
      $error("standard rates must be strictly increasing");
   end

   lcs_state_t        st;
   logic [PIX_W-1:0]  pix_q;
   logic [BPP_W-1:0]  bpp_q, bpp_in;
   logic [LANE_W-1:0] maxl_q;
   logic [RATE_W-1:0] maxr_q;
   logic              cap_q, fix_q;
   logic [CNT_W-1:0]  cand_l;
   logic [1:0]        ridx;
   logic [RATE_W-1:0] cand_r, try_r;
   logic              fits;

   lcs_bpp #(.BPC_W(BPC_W), .BPP_W(BPP_W)) u_bpp (
      .bpc (bpc),
      .bpp (bpp_in)
   );

   always_comb begin
      case (ridx)
         2'd0:    cand_r = R_LO;
         2'd1:    cand_r = R_MID;
         default: cand_r = R_HI;
      endcase
      try_r = (st == ST_LANE) ? maxr_q : cand_r;
   end

   lcs_fit #(
      .PIX_W(PIX_W), .BPP_W(BPP_W), .RATE_W(RATE_W),
      .CNT_W(CNT_W), .PROD_W(PROD_W)
   ) u_fit (
      .pix   (pix_q),
      .bpp   (bpp_q),
      .rate  (try_r),
      .lanes (cand_l),
      .fits  (fits)
   );

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pix_q   <= '0;
         bpp_q   <= '0;
         maxl_q  <= '0;
         maxr_q  <= '0;
         cap_q   <= 1'b0;
         fix_q   <= 1'b0;
         cand_l  <= '0;
         ridx    <= '0;
         done    <= 1'b0;
         lanes   <= '0;
         rate    <= '0;
         mode_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  pix_q  <= pix_khz;
                  bpp_q  <= bpp_in;
                  maxl_q <= sink_lanes;
                  maxr_q <= sink_rate;
                  cap_q  <= fast_cap;
                  fix_q  <= bridge_fix;
                  cand_l <= CNT_W'(1);
                  ridx   <= '0;
                  st     <= ST_LANE;
               end
            end
            ST_LANE: begin
               if (fits || (cand_l >= {1'b0, maxl_q})) begin
                  if (fix_q) begin
                     lanes   <= cand_l;
                     rate    <= R_MID;
                     mode_ok <= 1'b1;
                     done    <= 1'b1;
                     st      <= ST_IDLE;
                  end else begin
                     ridx <= '0;
                     st   <= ST_RATE;
                  end
               end else begin
                  cand_l <= cand_l << 1;
               end
            end
            ST_RATE: begin
               if (fits) begin
                  lanes   <= cand_l;
                  rate    <= cand_r;
                  mode_ok <= !((cand_r == R_HI) && !cap_q);
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end else if ((ridx == 2'd2) || ((ridx == 2'd1) && !cap_q)) begin
                  lanes   <= cand_l;
                  rate    <= maxr_q;
                  mode_ok <= !((maxr_q == R_HI) && !cap_q);
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end else begin
                  ridx <= ridx + 2'd1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lcs_chk.sv
module lcs_chk #(
   parameter int LANE_W  = 3,
   parameter int RATE_W  = 20,
   parameter int RATE_HI = 540000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [LANE_W:0]   lanes,
   input logic [RATE_W-1:0] rate,
   input logic              mode_ok
);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(lanes) && $stable(rate) && $stable(mode_ok)));

   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(lanes) || done));

   p_lanes_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot(lanes));

   p_invalid_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_ok) |-> (rate == RATE_W'(RATE_HI)));
endmodule

bind link_cfg_sel lcs_chk #(
   .LANE_W(LANE_W), .RATE_W(RATE_W), .RATE_HI(RATE_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .lanes(lanes), .rate(rate), .mode_ok(mode_ok)
);

// File: tb/sim_link_cfg_sel.sv
module sim_link_cfg_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] pix_khz = '0;
   logic [3:0]  bpc = '0;
   logic [2:0]  sink_lanes = '0;
   logic [19:0] sink_rate = '0;
   logic        fast_cap = 1'b0;
   logic        bridge_fix = 1'b0;
   logic        busy, done, mode_ok;
   logic [3:0]  lanes;
   logic [19:0] rate;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   link_cfg_sel u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz), .bpc(bpc),
      .sink_lanes(sink_lanes), .sink_rate(sink_rate), .fast_cap(fast_cap),
      .bridge_fix(bridge_fix), .busy(busy), .done(done), .lanes(lanes),
      .rate(rate), .mode_ok(mode_ok)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int bpp_of(input int c);
      return (c == 0) ? 24 : 3 * c;
   endfunction

   function automatic bit fits(input int p, input int c, input int r, input int l);
      return p <= (r * l * 8) / bpp_of(c);
   endfunction

   function automatic int exp_lanes(input int p, input int c, input int ml, input int mr);
      int l = 1;
      while (l < ml) begin
         if (fits(p, c, mr, l)) break;
         l = l * 2;
      end
      return l;
   endfunction

   function automatic int exp_rate(input int p, input int c, input int ml, input int mr,
                                   input bit cap, input bit fix);
      int l = exp_lanes(p, c, ml, mr);
      if (fix) return 270000;
      if (fits(p, c, 162000, l)) return 162000;
      if (fits(p, c, 270000, l)) return 270000;
      if (cap && fits(p, c, 540000, l)) return 540000;
      return mr;
   endfunction

   // drive a request at a falling edge, wait for done, leave at the done cycle
   task automatic request(input int p, input int c, input int ml, input int mr,
                          input bit cap, input bit fix);
      int n = 0;
      @(negedge clk);
      pix_khz = 20'(p); bpc = 4'(c); sink_lanes = 3'(ml); sink_rate = 20'(mr);
      fast_cap = cap; bridge_fix = fix; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 50) begin
         @(negedge clk);
         n++;
      end
      check("R8 done seen", int'(done), 1);
   endtask

   task automatic run_and_check(input int p, input int c, input int ml, input int mr,
                                input bit cap, input bit fix);
      int er;
      request(p, c, ml, mr, cap, fix);
      er = exp_rate(p, c, ml, mr, cap, fix);
      check("R3 lanes", int'(lanes), exp_lanes(p, c, ml, mr));
      check("R4 rate", int'(rate), er);
      check("R7 mode_ok", int'(mode_ok), (er == 540000 && !cap) ? 0 : 1);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int bpcs[5]  = '{0, 6, 8, 10, 12};
      int mls[3]   = '{1, 2, 4};
      int mrs[3]   = '{162000, 270000, 540000};
      int pixs[10] = '{25000, 54000, 54001, 90000, 108000, 180000, 216000,
                       360000, 720000, 1000000};
      int l0, r0, k0;

      repeat (3) @(negedge clk);
      // R9 reset values
      check("R9 busy", int'(busy), 0);
      check("R9 done", int'(done), 0);
      check("R9 lanes", int'(lanes), 0);
      check("R9 rate", int'(rate), 0);
      check("R9 mode_ok", int'(mode_ok), 0);
      rst_n = 1'b1;

      // R2 exact bound: 1 lane at 162000, 24 bpp -> 54000 fits, 54001 does not
      request(54000, 8, 1, 540000, 1'b1, 1'b0);
      check("R2 bound fits rate", int'(rate), 162000);
      request(54001, 8, 1, 540000, 1'b1, 1'b0);
      check("R2 over bound rate", int'(rate), 270000);
      // R1: bpc 0 behaves as bpc 8
      request(90000, 0, 4, 270000, 1'b0, 1'b0);
      l0 = int'(lanes); r0 = int'(rate);
      request(90000, 8, 4, 270000, 1'b0, 1'b0);
      check("R1 bpc0 lanes", l0, int'(lanes));
      check("R1 bpc0 rate", r0, int'(rate));
      // R5: too fast without fast_cap falls back to sink rate; R7 flags it
      request(1000000, 8, 4, 540000, 1'b0, 1'b0);
      check("R5 fallback rate", int'(rate), 540000);
      check("R7 invalid", int'(mode_ok), 0);
      // R6: bridge pins 270000 even when 162000 would fit
      request(25000, 8, 4, 540000, 1'b1, 1'b1);
      check("R6 bridge rate", int'(rate), 270000);
      check("R6 bridge lanes", int'(lanes), 1);

      // R8: second start during search ignored; result belongs to first request
      @(negedge clk);
      pix_khz = 20'd25000; bpc = 4'd8; sink_lanes = 3'd4; sink_rate = 20'd270000;
      fast_cap = 1'b0; bridge_fix = 1'b0; start = 1'b1;
      @(negedge clk);
      pix_khz = 20'd700000; sink_rate = 20'd540000; fast_cap = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k0 = 0;
      while (!done && k0 < 50) begin
         @(negedge clk);
         k0++;
      end
      check("R8 first result lanes", int'(lanes), 1);
      check("R8 first result rate", int'(rate), 162000);
      k0 = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done || busy) k0++;
      end
      check("R8 no second run", k0, 0);
      check("R8 hold rate", int'(rate), 162000);

      // sweep
      foreach (bpcs[a])
         foreach (mls[b])
            foreach (mrs[c])
               for (int cap = 0; cap < 2; cap++)
                  for (int fix = 0; fix < 2; fix++)
                     foreach (pixs[d])
                        run_and_check(pixs[d], bpcs[a], mls[b], mrs[c], cap[0], fix[0]);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule